// File: doc/BRIEF.md
# Binary to Decimal Digit Memory Writer

This block takes an unsigned binary byte and a 12-bit base address. It turns the byte into three decimal digits and stores them as three consecutive bytes through a byte-wide memory write port. A request is made by raising `start` for one cycle while the unit is idle. The unit captures the value and the base address on that edge. It then runs an iterative shift-and-add-3 conversion, one bit per cycle, so no divider is needed.

When the conversion ends, the unit issues three writes on back-to-back cycles. The most significant digit goes first, at the base address, and the least significant digit goes last, at base plus two. Addresses wrap at the top of the 4096-byte space. A one-cycle `done` pulse closes the request. The memory and any instruction decoding are outside this block.

Top module: `bcd_mem_writer`

## Requirements
- R1: A `start` seen while `busy` is low is accepted. `busy` is high from the cycle after acceptance until it falls together with the `done` pulse.
- R2: A `start` seen while `busy` is high is ignored. The running request keeps its captured value, base address and timing, and no extra write is issued.
- R3: The hundreds digit is written at the base address, the tens digit at base+1 and the ones digit at base+2, in that order, on three consecutive cycles.
- R4: Each written byte carries one digit 0..9 in bits [3:0], with bits [7:4] zero. The hundreds digit never exceeds 2.
- R5: Every request raises `wr_en` for exactly three cycles. The first write appears 9 cycles after the accepting edge: 8 conversion steps plus one cycle.
- R6: Write addresses are computed modulo 4096, so a base of 0xFFE writes to 0xFFE, 0xFFF and then 0x000.
- R7: `done` is high for exactly one cycle, the cycle right after the third write. A `start` given in that same cycle is accepted.
- R8: While `rst` is high and after it is released, `busy`, `done` and `wr_en` are low until a request is accepted.
- R9: The extreme values convert correctly: 0 gives digits 0,0,0 and 255 gives digits 2,5,5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| value | input | 8 | Unsigned binary value to convert |
| base_addr | input | 12 | Address of the first (hundreds) digit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | 12 | Memory write address |
| wr_data | output | 8 | Memory write byte (digit in low nibble) |

## Verification
The bound checker watches several rules on every cycle. Written bytes must always hold a decimal digit with a clear upper nibble. Back-to-back write addresses must step by one modulo 4096, and the first write of a burst must carry a digit of at most 2. The checker also holds that `done` is a single pulse that follows the last write, and that writes only occur while `busy` is high. The properties cannot show that the digits are the right ones for the captured value, that an overlapping `start` leaves that value untouched, or that the burst begins exactly nine cycles after acceptance. The bench's cycle-by-cycle reference model shows these, over chosen values, wrapping base addresses, held-high `start` and back-to-back requests.

// File: rtl/bcd_store_pkg.sv
package bcd_store_pkg;

  // number of decimal digits needed for the largest w-bit unsigned value
  function automatic int dec_digits(input int w);
    longint top;
    int n;
    top = (longint'(1) << w) - 1;
    n = 1;
    while (top >= 10) begin
      top = top / 10;
      n = n + 1;
    end
    return n;
  endfunction

  // shift-and-add-3 correction applied before each shift
  function automatic logic [3:0] dd_adjust(input logic [3:0] d);
    return (d >= 4'd5) ? d + 4'd3 : d;
  endfunction

endpackage

// File: rtl/bcd_shift_conv.sv
module bcd_shift_conv
  import bcd_store_pkg::*;
#(
  parameter int W  = 8,
  parameter int ND = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [W-1:0]    bin,
  output logic [4*ND-1:0] digits,
  output logic            fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]    sh_q;
  logic [4*ND-1:0] bcd_q;
  logic [4*ND-1:0] adj;
  logic [CW-1:0]   cnt_q;

  for (genvar g = 0; g < ND; g++) begin : g_adj
    assign adj[4*g +: 4] = dd_adjust(bcd_q[4*g +: 4]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      bcd_q <= '0;
      cnt_q <= '0;
      fin   <= 1'b0;
    end else if (load) begin
      sh_q  <= bin;
      bcd_q <= '0;
      cnt_q <= CW'(W);
      fin   <= 1'b0;
    end else if (cnt_q != '0) begin
      {bcd_q, sh_q} <= {adj, sh_q} << 1;
      cnt_q         <= cnt_q - 1'b1;
      fin           <= (cnt_q == CW'(1));
    end else begin
      fin <= 1'b0;
    end
  end

  assign digits = bcd_q;

endmodule

// File: rtl/bcd_write_seq.sv
module bcd_write_seq #(
  parameter int ND     = 3,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [4*ND-1:0]   digits,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              last,
  output logic              fin
);
  localparam int SW = $clog2(ND + 1);

  logic          active_q;
  logic [SW-1:0] slot_q;

  assign last = active_q && (slot_q == SW'(ND));

  // digit slot s counts from the most significant digit
  function automatic logic [DATA_W-1:0] pick(input logic [4*ND-1:0] d,
                                             input int s);
    return {{(DATA_W-4){1'b0}}, d[4*(ND-1-s) +: 4]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        slot_q   <= SW'(1);
        wr_en    <= 1'b1;
        wr_addr  <= base;
        wr_data  <= pick(digits, 0);
      end else if (last) begin
        active_q <= 1'b0;
        wr_en    <= 1'b0;
        fin      <= 1'b1;
      end else if (active_q) begin
        wr_en    <= 1'b1;
        wr_addr  <= wr_addr + 1'b1;
        wr_data  <= pick(digits, int'(slot_q));
        slot_q   <= slot_q + 1'b1;
      end else begin
        wr_en <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bcd_mem_writer.sv
module bcd_mem_writer
  import bcd_store_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [W-1:0]      value,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int ND = dec_digits(W);

  logic              accept;
  logic              conv_fin;
  logic              seq_last;
  logic [4*ND-1:0]   digits;
  logic [ADDR_W-1:0] base_q;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      base_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      base_q <= base_addr;
    end else if (seq_last) begin
      busy <= 1'b0;
    end
  end

  bcd_shift_conv #(.W(W), .ND(ND)) u_conv (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .bin    (value),
    .digits (digits),
    .fin    (conv_fin)
  );

  bcd_write_seq #(.ND(ND), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go      (conv_fin),
    .base    (base_q),
    .digits  (digits),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .last    (seq_last),
    .fin     (done)
  );

endmodule

// File: rtl/bcd_mem_writer_chk.sv
module bcd_mem_writer_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);

  a_r4_digit_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[DATA_W-1:4] == '0) && (wr_data[3:0] <= 4'd9));

  a_r4_hundreds_max: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !$past(wr_en)) |-> (wr_data <= DATA_W'(2)));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wr_en) && !wr_en && !busy));

  a_r1_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r5_write_in_busy: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

endmodule

bind bcd_mem_writer bcd_mem_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data)
);

// File: tb/tb_bcd_mem_writer.sv
module tb_bcd_mem_writer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  value = '0;
  logic [11:0] base_addr = '0;
  logic        busy, done, wr_en;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int wr_count = 0;

  // reference model state: -1 idle, 0..12 cycles since acceptance
  int ph = -1;
  int m_val = 0;
  int m_base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_mem_writer dut (
    .clk(clk), .rst(rst), .start(start), .value(value),
    .base_addr(base_addr), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act,
                       input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) ph = -1;
    else if (start && (ph == -1 || ph == 12)) begin
      ph = 0; m_val = int'(value); m_base = int'(base_addr);
    end else if (ph >= 0 && ph < 12) ph = ph + 1;
    else if (ph == 12) ph = -1;
  end

  function automatic int exp_digit(input int v, input int k);
    if (k == 0) return v / 100;
    if (k == 1) return (v / 10) % 10;
    return v % 10;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      check(!busy && !done && !wr_en, "R8 reset outputs", {busy, done, wr_en}, 0);
    end else begin
      check(busy == (ph >= 0 && ph <= 11), "R1 busy", busy, ph >= 0 && ph <= 11);
      check(wr_en == (ph >= 9 && ph <= 11), "R5 wr_en timing", wr_en, ph >= 9 && ph <= 11);
      check(done == (ph == 12), "R7 done pulse", done, ph == 12);
      if (wr_en) wr_count++;
      if (ph >= 9 && ph <= 11) begin
        check(int'(wr_addr) == (m_base + ph - 9) % 4096, "R3/R6 address",
              int'(wr_addr), (m_base + ph - 9) % 4096);
        check(int'(wr_data) == exp_digit(m_val, ph - 9), "R4/R9 digit",
              int'(wr_data), exp_digit(m_val, ph - 9));
      end
    end
  end

  task automatic request(input int v, input int b);
    @(negedge clk);
    start = 1'b1; value = 8'(v); base_addr = 12'(b);
    @(negedge clk);
    start = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 extremes
    wr_count = 0; request(0, 12'h100);
    check(wr_count == 3, "R5 three writes", wr_count, 3);
    request(255, 12'h200);
    request(123, 12'h345);
    // R6 wrap cases
    request(123, 12'hFFE);
    request(99, 12'hFFF);

    // R2: start held high with other values while busy
    wr_count = 0;
    @(negedge clk);
    start = 1'b1; value = 8'd207; base_addr = 12'h010;
    @(negedge clk);
    value = 8'd31; base_addr = 12'h777;
    repeat (8) @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(wr_count == 3, "R2 ignored start adds no write", wr_count, 3);

    // R7: new start in the done cycle
    @(negedge clk);
    start = 1'b1; value = 8'd58; base_addr = 12'h020;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; value = 8'd170; base_addr = 12'h030;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 start during done accepted", busy, 1);
    repeat (14) @(negedge clk);

    for (int v = 1; v < 256; v += 17) request(v, 12'h400 + v);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule